// File: doc/BRIEF.md
# Carry-Select Adder with Prefix Groups and Increment Paths

A purely combinational adder that returns the sum of two operands and a carry-in, together with a carry-out. The operand width is cut into groups. Every group above the lowest uses a logarithmic-depth prefix adder to form its sum for an incoming carry of zero. An incrementer turns that sum, with its carry, into the result for an incoming carry of one. A two-way multiplexer, steered by the carry chosen in the group below, keeps one of the two results.

The lowest group has no incrementer and no multiplexer. Its prefix adder takes the external carry-in directly. A parameter selects how the width is split. The linear split uses equal groups. The square-root split uses groups that widen by one bit each step, so the upper groups have more time before their select carry arrives.

There are no registers, and the output settles from the inputs alone. Default parameters give a 16-bit adder with the linear split.

Top module: `bk_csel_adder`

## Requirements
- R1: For every a, b and cin, the 17-bit value {cout, sum} equals a + b + cin, under both splits.
- R2: With SQRT_SPLIT = 0, the width is cut into groups of LIN_BITS bits (four groups of four at the defaults). A carry that ends exactly at bit 4, 8 or 12 still gives the correct sum.
- R3: With SQRT_SPLIT = 1, the group sizes from least significant upward are 2, 2, 3, 4 and 5 bits, with boundaries at bits 2, 4, 7 and 11. A carry that ends exactly at any of those bits gives the correct sum.
- R4: The lowest group adds its operand slices and cin directly. Its result and carry equal a[lo] + b[lo] + cin over that slice.
- R5: In every upper group, the zero-carry path gives the slice sum a_g + b_g with its own carry-out, independent of any lower bits.
- R6: In every upper group, the incrementer output, taken as an (N+1)-bit value with its carry on top, equals the zero-carry path value plus one.
- R7: Each upper group outputs its zero-carry result when the carry from the group below is 0, and the incremented result when it is 1. The selected top bit is the carry that goes into the next group, and it equals the true arithmetic carry at that bit position.
- R8: cout is the selected carry of the most significant group. It equals bit 16 of a + b + cin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | first addend |
| b | input | WIDTH | second addend |
| cin | input | 1 | carry into bit 0 |
| sum | output | WIDTH | low WIDTH bits of a + b + cin |
| cout | output | 1 | carry out of the top bit |

## Verification
The checker's immediate assertions compare arithmetic values, so they assume that a, b and cin carry known 0/1 values and change only as a set. The internal group paths are then settled when each check is evaluated. The stimulus drives every input together, once per clock, at the falling edge. It uses only constants and $urandom words, so no unknown value ever reaches the adder. Carry chains get extra weight through random vectors in which b is close to the complement of a. Directed vectors end a carry at every bit position, which covers every group boundary of both splits.

// File: rtl/bk_csel_pkg.sv
package bk_csel_pkg;

  // Generate/propagate pair of one bit or one span of bits
  typedef struct packed {
    logic g;
    logic p;
  } pg_t;

  // Prefix operator: hi span sits above lo span
  function automatic pg_t pg_merge(pg_t hi, pg_t lo);
    pg_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

  // Width a group would have if the operand were unbounded
  function automatic int grp_nominal(bit sq, int lin, int first, int g);
    if (!sq) return lin;
    if (g == 0) return first;
    return first + g - 1;
  endfunction

  // Lowest bit index of group g, clamped to the operand width
  function automatic int grp_lo(int w, bit sq, int lin, int first, int g);
    int acc;
    acc = 0;
    for (int k = 0; k < g; k++) begin
      acc = acc + grp_nominal(sq, lin, first, k);
      if (acc > w) acc = w;
    end
    return acc;
  endfunction

  // Actual width of group g (the last group is trimmed)
  function automatic int grp_size(int w, bit sq, int lin, int first, int g);
    int lo;
    int nom;
    lo  = grp_lo(w, sq, lin, first, g);
    nom = grp_nominal(sq, lin, first, g);
    return ((w - lo) < nom) ? (w - lo) : nom;
  endfunction

  // Number of groups needed to cover w bits
  function automatic int grp_count(int w, bit sq, int lin, int first);
    int n;
    n = 0;
    while (grp_lo(w, sq, lin, first, n) < w) n++;
    return n;
  endfunction

endpackage

// File: rtl/bk_prefix_adder.sv
module bk_prefix_adder
  import bk_csel_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout
);

  localparam int LEVELS = (N > 1) ? $clog2(N) : 0;

  pg_t        bit_pg [N];
  pg_t        span_pg [N];   // span_pg[i] covers bits i down to 0
  logic [N:0] carry;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      bit_pg[i].g = a[i] & b[i];
      bit_pg[i].p = a[i] ^ b[i];
    end
  end

  // Sparse tree: up-sweep builds power-of-two spans, down-sweep fills gaps.
  // The node read at each level is never written at that level.
  always_comb begin
    for (int i = 0; i < N; i++) span_pg[i] = bit_pg[i];
    for (int l = 0; l < LEVELS; l++) begin
      for (int i = 0; i < N; i++) begin
        if (((i + 1) % (1 << (l + 1))) == 0)
          span_pg[i] = pg_merge(span_pg[i], span_pg[i - (1 << l)]);
      end
    end
    for (int l = LEVELS - 2; l >= 0; l--) begin
      for (int i = 0; i < N; i++) begin
        if ((((i + 1) % (1 << (l + 1))) == (1 << l)) && (i >= (1 << (l + 1))))
          span_pg[i] = pg_merge(span_pg[i], span_pg[i - (1 << l)]);
      end
    end
  end

  always_comb begin
    carry[0] = cin;
    for (int i = 0; i < N; i++) begin
      carry[i+1] = span_pg[i].g | (span_pg[i].p & cin);
      sum[i]     = bit_pg[i].p ^ carry[i];
    end
  end

  assign cout = carry[N];

endmodule

// File: rtl/bk_excess_one.sv
module bk_excess_one #(
  parameter int N = 5
) (
  input  logic [N-1:0] x,
  output logic [N-1:0] y
);

  // Bit i flips when every bit below it is one
  logic [N-1:0] all_below;

  always_comb begin
    all_below[0] = 1'b1;
    for (int i = 1; i < N; i++) all_below[i] = all_below[i-1] & x[i-1];
  end

  assign y = x ^ all_below;

endmodule

// File: rtl/bk_csel_group.sv
module bk_csel_group #(
  parameter int N = 4
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         carry_in,
  output logic [N-1:0] sum,
  output logic         cout,
  output logic [N-1:0] zero_sum,
  output logic         zero_cout,
  output logic [N-1:0] inc_sum,
  output logic         inc_cout
);

  logic [N:0] inc_v;

  bk_prefix_adder #(.N(N)) zero_add (
    .a    (a),
    .b    (b),
    .cin  (1'b0),
    .sum  (zero_sum),
    .cout (zero_cout)
  );

  bk_excess_one #(.N(N + 1)) plus_one (
    .x ({zero_cout, zero_sum}),
    .y (inc_v)
  );

  assign {inc_cout, inc_sum} = inc_v;
  assign {cout, sum} = carry_in ? inc_v : {zero_cout, zero_sum};

endmodule

// File: rtl/bk_csel_adder.sv
module bk_csel_adder
  import bk_csel_pkg::*;
#(
  parameter int WIDTH      = 16,
  parameter bit SQRT_SPLIT = 1'b0,
  parameter int LIN_BITS   = 4,
  parameter int SQ_FIRST   = 2
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int NGRP = grp_count(WIDTH, SQRT_SPLIT, LIN_BITS, SQ_FIRST);

  // Named internal events for the checker
  logic [NGRP:0]    grp_carry;     // carry entering each group; top = cout
  logic [WIDTH-1:0] zero_sum_w;    // per-group zero-carry sums
  logic [NGRP-1:0]  zero_cout_w;
  logic [WIDTH-1:0] inc_sum_w;     // per-group incremented sums
  logic [NGRP-1:0]  inc_cout_w;

  assign grp_carry[0] = cin;

  for (genvar g = 0; g < NGRP; g++) begin : grp
    localparam int LO = grp_lo(WIDTH, SQRT_SPLIT, LIN_BITS, SQ_FIRST, g);
    localparam int SZ = grp_size(WIDTH, SQRT_SPLIT, LIN_BITS, SQ_FIRST, g);

    if (g == 0) begin : base
      // Lowest group takes cin directly: no select path to wait for
      bk_prefix_adder #(.N(SZ)) base_add (
        .a    (a[LO +: SZ]),
        .b    (b[LO +: SZ]),
        .cin  (cin),
        .sum  (sum[LO +: SZ]),
        .cout (grp_carry[g+1])
      );
      assign zero_sum_w[LO +: SZ] = sum[LO +: SZ];
      assign inc_sum_w[LO +: SZ]  = sum[LO +: SZ];
      assign zero_cout_w[g]       = grp_carry[g+1];
      assign inc_cout_w[g]        = grp_carry[g+1];
    end else begin : upper
      bk_csel_group #(.N(SZ)) sel_grp (
        .a         (a[LO +: SZ]),
        .b         (b[LO +: SZ]),
        .carry_in  (grp_carry[g]),
        .sum       (sum[LO +: SZ]),
        .cout      (grp_carry[g+1]),
        .zero_sum  (zero_sum_w[LO +: SZ]),
        .zero_cout (zero_cout_w[g]),
        .inc_sum   (inc_sum_w[LO +: SZ]),
        .inc_cout  (inc_cout_w[g])
      );
    end
  end

  assign cout = grp_carry[NGRP];

endmodule

// File: rtl/bk_csel_chk.sv
module bk_csel_chk
  import bk_csel_pkg::*;
#(
  parameter int WIDTH      = 16,
  parameter bit SQRT_SPLIT = 1'b0,
  parameter int LIN_BITS   = 4,
  parameter int SQ_FIRST   = 2,
  parameter int NGRP       = 4
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic [NGRP:0]    grp_carry,
  input logic [WIDTH-1:0] zero_sum_w,
  input logic [NGRP-1:0]  zero_cout_w,
  input logic [WIDTH-1:0] inc_sum_w,
  input logic [NGRP-1:0]  inc_cout_w
);

  localparam logic [WIDTH:0] ONE = {{WIDTH{1'b0}}, 1'b1};

  always_comb begin
    logic [WIDTH:0] full, part, lowm, msk, a_g, b_g, c_ext;
    logic [WIDTH:0] zero_v, inc_v, pick_v;
    int lo, sz;
    c_ext = {{WIDTH{1'b0}}, cin};
    full  = {1'b0, a} + {1'b0, b} + c_ext;
    // R1
    total_sum_chk: assert ({cout, sum} == full)
      else $error("R1 total %h expected %h", {cout, sum}, full);
    // R8
    top_carry_chk: assert (cout == full[WIDTH])
      else $error("R8 cout %b", cout);
    for (int g = 0; g < NGRP; g++) begin
      lo     = grp_lo(WIDTH, SQRT_SPLIT, LIN_BITS, SQ_FIRST, g);
      sz     = grp_size(WIDTH, SQRT_SPLIT, LIN_BITS, SQ_FIRST, g);
      lowm   = (ONE << lo) - ONE;
      msk    = (ONE << sz) - ONE;
      part   = ({1'b0, a} & lowm) + ({1'b0, b} & lowm) + c_ext;
      a_g    = ({1'b0, a} >> lo) & msk;
      b_g    = ({1'b0, b} >> lo) & msk;
      zero_v = (({1'b0, zero_sum_w} >> lo) & msk) | ({{WIDTH{1'b0}}, zero_cout_w[g]} << sz);
      inc_v  = (({1'b0, inc_sum_w} >> lo) & msk) | ({{WIDTH{1'b0}}, inc_cout_w[g]} << sz);
      pick_v = (({1'b0, sum} >> lo) & msk) | ({{WIDTH{1'b0}}, grp_carry[g+1]} << sz);
      // R7
      boundary_carry_chk: assert (grp_carry[g] == part[lo])
        else $error("R7 carry into group %0d wrong", g);
      if (g == 0) begin
        // R4
        base_group_chk: assert (pick_v == a_g + b_g + c_ext)
          else $error("R4 base group %h", pick_v);
      end else begin
        // R5
        zero_path_chk: assert (zero_v == a_g + b_g)
          else $error("R5 group %0d zero path %h", g, zero_v);
        // R6
        excess_one_chk: assert (inc_v == zero_v + ONE)
          else $error("R6 group %0d increment %h", g, inc_v);
        // R7
        select_chk: assert (pick_v == (grp_carry[g] ? inc_v : zero_v))
          else $error("R7 group %0d select %h", g, pick_v);
      end
    end
  end

endmodule

bind bk_csel_adder bk_csel_chk #(
  .WIDTH      (WIDTH),
  .SQRT_SPLIT (SQRT_SPLIT),
  .LIN_BITS   (LIN_BITS),
  .SQ_FIRST   (SQ_FIRST),
  .NGRP       (NGRP)
) chk_i (
  .a           (a),
  .b           (b),
  .cin         (cin),
  .sum         (sum),
  .cout        (cout),
  .grp_carry   (grp_carry),
  .zero_sum_w  (zero_sum_w),
  .zero_cout_w (zero_cout_w),
  .inc_sum_w   (inc_sum_w),
  .inc_cout_w  (inc_cout_w)
);

// File: tb/bk_csel_adder_tb.sv
`timescale 1ns/1ps
module bk_csel_adder_tb_top;

  localparam int W = 16;
  localparam int MAX_CYCLES = 200000;

  logic         clk = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic         cin_in = 1'b0;
  logic [W-1:0] sum_lin, sum_sq;
  logic         cout_lin, cout_sq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bk_csel_adder #(.WIDTH(W), .SQRT_SPLIT(1'b0)) dut_i (
    .a (a_in), .b (b_in), .cin (cin_in), .sum (sum_lin), .cout (cout_lin)
  );

  bk_csel_adder #(.WIDTH(W), .SQRT_SPLIT(1'b1)) dut_sq_i (
    .a (a_in), .b (b_in), .cin (cin_in), .sum (sum_sq), .cout (cout_sq)
  );

  // Bit-serial reference, written as a ripple
  function automatic logic [W:0] ref_add(logic [W-1:0] x, logic [W-1:0] y, logic c);
    logic [W:0] r;
    logic k;
    k = c;
    for (int i = 0; i < W; i++) begin
      r[i] = x[i] ^ y[i] ^ k;
      k    = (x[i] & y[i]) | (k & (x[i] ^ y[i]));
    end
    r[W] = k;
    return r;
  endfunction

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic c, input string tag);
    logic [W:0] exp_v;
    @(negedge clk);
    a_in = x; b_in = y; cin_in = c;
    #1;
    exp_v = ref_add(x, y, c);
    n_checks++;
    if ({cout_lin, sum_lin} !== exp_v) begin
      n_fail++;
      $display("FAIL %s linear a=%h b=%h cin=%b: actual %h expected %h",
               tag, x, y, c, {cout_lin, sum_lin}, exp_v);
    end
    n_checks++;
    if ({cout_sq, sum_sq} !== exp_v) begin
      n_fail++;
      $display("FAIL %s sqrt a=%h b=%h cin=%b: actual %h expected %h",
               tag, x, y, c, {cout_sq, sum_sq}, exp_v);
    end
  endtask

  initial begin
    #(5.0 * MAX_CYCLES);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] ra, rb;
    int unsigned seed_v;
    seed_v = $urandom(32'd20240611);

    // R1 idle inputs give zero
    apply('0, '0, 1'b0, "R1 zero");
    apply('0, '0, 1'b1, "R1 cin only");

    // R8 carry out of the top
    apply('1, '1, 1'b1, "R8 all ones plus cin");
    apply('1, '0, 1'b1, "R8 ripple through every group");
    apply('1, 16'h0001, 1'b0, "R8 generate at bit 0");
    apply(16'h8000, 16'h8000, 1'b0, "R8 top generate");

    // R2 (boundaries 4,8,12) and R3 (boundaries 2,4,7,11): carry ends at bit k
    for (int k = 1; k <= W; k++) begin
      apply(W'((17'h1 << k) - 17'h1), '0, 1'b1, "R2 R3 carry end");
      apply(W'((17'h1 << k) - 17'h1), W'(17'h1 << (k - 1)), 1'b0, "R2 R3 carry gen");
    end

    // R4 lowest group with cin
    apply(16'h0003, 16'h0000, 1'b1, "R4 base carry out");
    apply(16'h0001, 16'h0002, 1'b1, "R4 base wrap");

    // R5 carry generated inside an upper group, nothing from below
    apply(16'h0F00, 16'h0100, 1'b0, "R5 upper generate");
    apply(16'hA5A0, 16'h5A50, 1'b0, "R5 propagate no carry");

    // R6 incoming carry flips a run of ones
    apply(16'hFFF0, 16'h0010, 1'b0, "R6 increment run");
    apply(16'h7FFF, 16'h0001, 1'b0, "R6 increment to top");

    // R7 same upper bits, incoming carry 0 then 1
    apply(16'h1230, 16'h0450, 1'b0, "R7 select zero");
    apply(16'h123F, 16'h0001, 1'b0, "R7 select one");
    apply(16'h1230, 16'h0450, 1'b1, "R7 select zero cin");
    apply(16'h123F, 16'h0000, 1'b1, "R7 select one cin");

    // R1 random, with carry-chain-heavy mixes
    for (int n = 0; n < 3000; n++) begin
      ra = W'($urandom);
      case ($urandom % 4)
        0: rb = ~ra;
        1: rb = ~ra ^ W'(1 << ($urandom % W));
        default: rb = W'($urandom);
      endcase
      apply(ra, rb, 1'($urandom), "R1 random");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule